// File: doc/BRIEF.md
# SPI Controller Interrupt Status Unit

This block turns FIFO occupancy and fault events of an SPI controller into a seven-bit status word, a seven-bit interrupt mask and a single interrupt line. It compares the transmit and receive FIFO fill counts against two programmable thresholds each cycle. It also watches three kinds of event: a push into a full receive FIFO, a pop from an empty transmit FIFO, and a mode-fault pulse. Any of these sets a sticky status bit.

Software reaches the block through a simple register write port and a combinational read port. Status bits are cleared by writing ones. The mask has no read-write register of its own. It is set through one write-one address, cleared through another, and read back from a third. The interrupt output is high whenever a set status bit is also enabled in the mask.

Top module: `spi_irq_status`

## Requirements
- R1: After reset the mask reads 0, both thresholds read 1, the status reads 0 and `irq` is 0. Register offsets: status 0x04, mask-set 0x08, mask-clear 0x0C, mask readback 0x10, TX threshold 0x28, RX threshold 0x2C. Reads of 0x08, 0x0C and any unmapped offset return 0, and writes to 0x10 are ignored.
- R2: Writing to 0x08 sets every mask bit whose data bit (6:0) is one and leaves the other mask bits unchanged.
- R3: Writing to 0x0C clears every mask bit whose data bit (6:0) is one and leaves the other mask bits unchanged.
- R4: Writing to 0x04 clears every status bit whose data bit is one. For the condition-driven bits 2, 3, 4 and 5, the clear wins in the cycle of the write.
- R5: Status bit 2 is set in any cycle where the TX fill count is below the TX threshold.
- R6: Status bit 4 is set in any cycle where the RX fill count is nonzero.
- R7: Status bit 3 is set in any cycle where the RX fill count is at or above the RX threshold.
- R8: Status bit 5 is set in any cycle where the TX fill count is at or above the FIFO depth.
- R9: Status bit 0 is set by an RX push attempt while the RX fill count is at or above the depth. Status bit 1 is set by a mode-fault pulse. Status bit 6 is set by a TX pop attempt while the TX fill count is 0. For these event bits, a new event wins over a clear written in the same cycle.
- R10: Every status bit stays set until it is cleared. After a clear, a condition-driven bit sets again one cycle later if its condition still holds. An event bit stays clear until a new event occurs.
- R11: `irq` is high exactly when some status bit and the same mask bit are both one. It follows the registered status and mask with no added delay.
- R12: A write to a threshold register stores the written value. If the value exceeds the FIFO depth, the register holds the depth instead. Changes take effect for comparisons from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_waddr | input | 8 | Write byte offset |
| reg_wdata | input | DATA_W | Write data |
| reg_raddr | input | 8 | Read byte offset |
| reg_rdata | output | DATA_W | Read data (combinational) |
| tx_level | input | CNT_W | TX FIFO fill count |
| rx_level | input | CNT_W | RX FIFO fill count |
| rx_push_try | input | 1 | RX FIFO push attempt this cycle |
| tx_pop_try | input | 1 | TX FIFO pop attempt this cycle |
| mode_fault | input | 1 | Mode-fault pulse |
| irq | output | 1 | Interrupt request |

## Verification
Random fill counts are biased toward 0, 1, the programmed thresholds and the depth, so each comparison is tried exactly at its edge and one step away. Clears land while a bit's condition still holds and again after it has gone. This separates re-arming condition bits from event bits that must stay clear. Events that coincide with a clear of their own bit show whether the event wins. Random threshold writes above the depth check the clamp, and random mask writes show that enable and disable touch only the addressed bits.

// File: rtl/irq_stat_pkg.sv
package irq_stat_pkg;
    timeunit 1ns;
    timeprecision 100ps;

    localparam int STAT_W = 7;
    localparam int OFS_W  = 8;

    localparam logic [OFS_W-1:0] OFS_STATUS = 8'h04;
    localparam logic [OFS_W-1:0] OFS_MSET   = 8'h08;
    localparam logic [OFS_W-1:0] OFS_MCLR   = 8'h0C;
    localparam logic [OFS_W-1:0] OFS_MASK   = 8'h10;
    localparam logic [OFS_W-1:0] OFS_TXTHR  = 8'h28;
    localparam logic [OFS_W-1:0] OFS_RXTHR  = 8'h2C;

    // status bit positions
    localparam int B_RX_OVF   = 0;
    localparam int B_MODE_FLT = 1;
    localparam int B_TX_LOW   = 2;
    localparam int B_RX_HIGH  = 3;
    localparam int B_RX_AVAIL = 4;
    localparam int B_TX_FULL  = 5;
    localparam int B_TX_UNDF  = 6;

    // bits driven by a condition (clear wins), the rest are events (set wins)
    localparam logic [STAT_W-1:0] LEVEL_BITS = 7'b0111100;

    typedef struct packed {
        logic stat_clr;
        logic mask_set;
        logic mask_clr;
        logic txthr_wr;
        logic rxthr_wr;
    } wr_strobe_t;
endpackage

// File: rtl/irq_reg_decode.sv
module irq_reg_decode
    import irq_stat_pkg::*;
(
    input  logic             we,
    input  logic [OFS_W-1:0] addr,
    output wr_strobe_t       strb
);
    timeunit 1ns;
    timeprecision 100ps;

    always_comb begin
        strb          = '0;
        strb.stat_clr = we && (addr == OFS_STATUS);
        strb.mask_set = we && (addr == OFS_MSET);
        strb.mask_clr = we && (addr == OFS_MCLR);
        strb.txthr_wr = we && (addr == OFS_TXTHR);
        strb.rxthr_wr = we && (addr == OFS_RXTHR);
    end
endmodule

// File: rtl/irq_cond_gen.sv
module irq_cond_gen
    import irq_stat_pkg::*;
#(
    parameter int FIFO_DEPTH = 64,
    parameter int CNT_W      = 7
) (
    input  logic [CNT_W-1:0]  tx_level,
    input  logic [CNT_W-1:0]  rx_level,
    input  logic [CNT_W-1:0]  tx_thr,
    input  logic [CNT_W-1:0]  rx_thr,
    input  logic              rx_push_try,
    input  logic              tx_pop_try,
    input  logic              mode_fault,
    output logic [STAT_W-1:0] hits
);
    timeunit 1ns;
    timeprecision 100ps;

    localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(FIFO_DEPTH);

    logic rx_full, tx_empty;
    assign rx_full  = rx_level >= DEPTH_C;
    assign tx_empty = tx_level == '0;

    always_comb begin
        hits             = '0;
        hits[B_RX_OVF]   = rx_push_try && rx_full;
        hits[B_MODE_FLT] = mode_fault;
        hits[B_TX_LOW]   = tx_level < tx_thr;
        hits[B_RX_HIGH]  = rx_level >= rx_thr;
        hits[B_RX_AVAIL] = rx_level != '0;
        hits[B_TX_FULL]  = tx_level >= DEPTH_C;
        hits[B_TX_UNDF]  = tx_pop_try && tx_empty;
    end
endmodule

// File: rtl/irq_stat_bank.sv
module irq_stat_bank
    import irq_stat_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  wr_strobe_t        strb,
    input  logic [STAT_W-1:0] wbits,
    input  logic [STAT_W-1:0] hits,
    output logic [STAT_W-1:0] stat_q,
    output logic [STAT_W-1:0] mask_q
);
    timeunit 1ns;
    timeprecision 100ps;

    logic [STAT_W-1:0] clr, stat_d, mask_d;

    assign clr = strb.stat_clr ? wbits : '0;

    for (genvar i = 0; i < STAT_W; i++) begin : g_bit
        if (LEVEL_BITS[i]) begin : g_level
            assign stat_d[i] = (stat_q[i] | hits[i]) & ~clr[i];
        end else begin : g_event
            assign stat_d[i] = (stat_q[i] & ~clr[i]) | hits[i];
        end
    end

    always_comb begin
        mask_d = mask_q;
        if (strb.mask_set) mask_d = mask_d | wbits;
        if (strb.mask_clr) mask_d = mask_d & ~wbits;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q <= '0;
            mask_q <= '0;
        end else begin
            stat_q <= stat_d;
            mask_q <= mask_d;
        end
    end
endmodule

// File: rtl/spi_irq_status.sv
module spi_irq_status
    import irq_stat_pkg::*;
#(
    parameter int FIFO_DEPTH = 64,
    parameter int CNT_W      = $clog2(FIFO_DEPTH + 1),
    parameter int DATA_W     = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [OFS_W-1:0]  reg_waddr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic [OFS_W-1:0]  reg_raddr,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [CNT_W-1:0]  tx_level,
    input  logic [CNT_W-1:0]  rx_level,
    input  logic              rx_push_try,
    input  logic              tx_pop_try,
    input  logic              mode_fault,
    output logic              irq
);
    timeunit 1ns;
    timeprecision 100ps;

    localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(FIFO_DEPTH);
    localparam logic [CNT_W-1:0] THR_RST = CNT_W'(1);

    wr_strobe_t        strb;
    logic [STAT_W-1:0] hits, stat_q, mask_q;
    logic [CNT_W-1:0]  tx_thr_q, rx_thr_q, thr_wval;
    logic              thr_too_big;

    irq_reg_decode u_dec (
        .we   (reg_we),
        .addr (reg_waddr),
        .strb (strb)
    );

    irq_cond_gen #(.FIFO_DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)) u_cond (
        .tx_level    (tx_level),
        .rx_level    (rx_level),
        .tx_thr      (tx_thr_q),
        .rx_thr      (rx_thr_q),
        .rx_push_try (rx_push_try),
        .tx_pop_try  (tx_pop_try),
        .mode_fault  (mode_fault),
        .hits        (hits)
    );

    irq_stat_bank u_bank (
        .clk    (clk),
        .rst    (rst),
        .strb   (strb),
        .wbits  (reg_wdata[STAT_W-1:0]),
        .hits   (hits),
        .stat_q (stat_q),
        .mask_q (mask_q)
    );

    // threshold write value, clamped to the FIFO depth
    assign thr_too_big = (|reg_wdata[DATA_W-1:CNT_W]) || (reg_wdata[CNT_W-1:0] > DEPTH_C);
    assign thr_wval    = thr_too_big ? DEPTH_C : reg_wdata[CNT_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_thr_q <= THR_RST;
            rx_thr_q <= THR_RST;
        end else begin
            if (strb.txthr_wr) tx_thr_q <= thr_wval;
            if (strb.rxthr_wr) rx_thr_q <= thr_wval;
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_raddr)
            OFS_STATUS: reg_rdata[STAT_W-1:0] = stat_q;
            OFS_MASK:   reg_rdata[STAT_W-1:0] = mask_q;
            OFS_TXTHR:  reg_rdata[CNT_W-1:0]  = tx_thr_q;
            OFS_RXTHR:  reg_rdata[CNT_W-1:0]  = rx_thr_q;
            default:    reg_rdata = '0;
        endcase
    end

    assign irq = |(stat_q & mask_q);
endmodule

// File: rtl/irq_status_chk.sv
module irq_status_chk
    import irq_stat_pkg::*;
#(
    parameter int CNT_W = 7
) (
    input logic              clk,
    input logic              rst,
    input logic              reg_we,
    input logic [OFS_W-1:0]  reg_waddr,
    input logic [STAT_W-1:0] wbits,
    input logic [CNT_W-1:0]  rx_level,
    input logic              mode_fault,
    input logic [STAT_W-1:0] stat_q,
    input logic [STAT_W-1:0] mask_q,
    input logic              irq
);
    timeunit 1ns;
    timeprecision 100ps;

    logic st_wr;
    assign st_wr = reg_we && (reg_waddr == OFS_STATUS);

    AST_MASK_SET: assert property (@(posedge clk) disable iff (rst)
        (reg_we && reg_waddr == OFS_MSET) |=> ((mask_q & $past(wbits)) == $past(wbits))); // R2
    AST_MASK_CLR: assert property (@(posedge clk) disable iff (rst)
        (reg_we && reg_waddr == OFS_MCLR) |=> ((mask_q & $past(wbits)) == '0)); // R3
    AST_LEVEL_CLEAR_WINS: assert property (@(posedge clk) disable iff (rst)
        (st_wr && wbits[B_TX_LOW]) |=> !stat_q[B_TX_LOW]); // R4
    AST_RX_AVAIL: assert property (@(posedge clk) disable iff (rst)
        (rx_level != '0 && !(st_wr && wbits[B_RX_AVAIL])) |=> stat_q[B_RX_AVAIL]); // R6
    AST_MODE_FAULT_SET: assert property (@(posedge clk) disable iff (rst)
        mode_fault |=> stat_q[B_MODE_FLT]); // R9
    AST_EVENT_STICKY: assert property (@(posedge clk) disable iff (rst)
        (stat_q[B_RX_OVF] && !(st_wr && wbits[B_RX_OVF])) |=> stat_q[B_RX_OVF]); // R10
    AST_NO_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
        (mask_q == '0) |-> !irq); // R11
endmodule

bind spi_irq_status irq_status_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .reg_we     (reg_we),
    .reg_waddr  (reg_waddr),
    .wbits      (reg_wdata[irq_stat_pkg::STAT_W-1:0]),
    .rx_level   (rx_level),
    .mode_fault (mode_fault),
    .stat_q     (stat_q),
    .mask_q     (mask_q),
    .irq        (irq)
);

// File: tb/sim_spi_irq_status.sv
module sim_spi_irq_status;
    timeunit 1ns;
    timeprecision 100ps;

    localparam int DEPTH = 64;
    localparam int CW    = 7;
    localparam int DW    = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          reg_we = 1'b0;
    logic [7:0]    reg_waddr = '0;
    logic [DW-1:0] reg_wdata = '0;
    logic [7:0]    reg_raddr = '0;
    logic [DW-1:0] reg_rdata;
    logic [CW-1:0] tx_level = '0;
    logic [CW-1:0] rx_level = '0;
    logic          rx_push_try = 1'b0;
    logic          tx_pop_try = 1'b0;
    logic          mode_fault = 1'b0;
    logic          irq;

    int checks = 0;
    int errors = 0;

    logic [6:0]    e_stat = '0;
    logic [6:0]    e_mask = '0;
    logic [CW-1:0] e_txth = CW'(1);
    logic [CW-1:0] e_rxth = CW'(1);

    always #2.5 clk = ~clk;

    spi_irq_status #(.FIFO_DEPTH(DEPTH), .CNT_W(CW), .DATA_W(DW)) u0 (
        .clk, .rst, .reg_we, .reg_waddr, .reg_wdata, .reg_raddr, .reg_rdata,
        .tx_level, .rx_level, .rx_push_try, .tx_pop_try, .mode_fault, .irq
    );

    function automatic string bit_tag(int b);
        case (b)
            2: return "R5";
            3: return "R7";
            4: return "R6";
            5: return "R8";
            default: return "R9";
        endcase
    endfunction

    function automatic logic [CW-1:0] clamp_thr(logic [DW-1:0] v);
        return (v > DW'(DEPTH)) ? CW'(DEPTH) : v[CW-1:0];
    endfunction

    task automatic chk(string what, logic [DW-1:0] act, logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", what, act, exp, $time);
        end
    endtask

    task automatic read_chk(logic [7:0] a, string what, logic [DW-1:0] exp);
        reg_raddr = a;
        #0.2;
        chk(what, reg_rdata, exp);
    endtask

    // one clock cycle: drive, advance the model, check after the edge
    task automatic step(logic we, logic [7:0] wa, logic [DW-1:0] wd,
                        logic [CW-1:0] txl, logic [CW-1:0] rxl,
                        logic push, logic pop, logic mf);
        logic [6:0] cond, clr, wb;
        @(negedge clk);
        reg_we = we; reg_waddr = wa; reg_wdata = wd;
        tx_level = txl; rx_level = rxl;
        rx_push_try = push; tx_pop_try = pop; mode_fault = mf;
        wb   = wd[6:0];
        cond = '0;
        cond[0] = push && (rxl >= CW'(DEPTH));
        cond[1] = mf;
        cond[2] = txl < e_txth;
        cond[3] = rxl >= e_rxth;
        cond[4] = rxl != '0;
        cond[5] = txl >= CW'(DEPTH);
        cond[6] = pop && (txl == '0);
        clr = (we && wa == 8'h04) ? wb : '0;
        // condition bits 2..5: clear wins; event bits 0,1,6: event wins
        e_stat = (((e_stat | cond) & ~clr) & 7'b0111100)
               | (((e_stat & ~clr) | cond) & 7'b1000011);
        if (we && wa == 8'h08) e_mask = e_mask | wb;
        if (we && wa == 8'h0C) e_mask = e_mask & ~wb;
        if (we && wa == 8'h28) e_txth = clamp_thr(wd);
        if (we && wa == 8'h2C) e_rxth = clamp_thr(wd);
        @(posedge clk);
        #0.5;
        reg_raddr = 8'h04;
        #0.2;
        for (int b = 0; b < 7; b++)
            chk($sformatf("%s R4 R10 status bit %0d", bit_tag(b), b),
                DW'(reg_rdata[b]), DW'(e_stat[b]));
        read_chk(8'h10, "R1 R2 R3 mask", DW'(e_mask));
        read_chk(8'h28, "R12 tx threshold", DW'(e_txth));
        read_chk(8'h2C, "R12 rx threshold", DW'(e_rxth));
        chk("R11 irq", DW'(irq), DW'(|(e_stat & e_mask)));
    endtask

    task automatic idle(logic [CW-1:0] txl, logic [CW-1:0] rxl);
        step(1'b0, 8'h00, '0, txl, rxl, 1'b0, 1'b0, 1'b0);
    endtask

    function automatic logic [CW-1:0] pick_level(logic [CW-1:0] thr);
        case ($urandom_range(0, 5))
            0: return '0;
            1: return CW'(1);
            2: return thr;
            3: return (thr == '0) ? '0 : thr - CW'(1);
            4: return CW'(DEPTH);
            default: return CW'($urandom_range(0, DEPTH));
        endcase
    endfunction

    initial begin
        #1000000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=hung expected=done (R11)");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        // reset state, R1
        repeat (3) @(posedge clk);
        #0.5;
        read_chk(8'h04, "R1 reset status", '0);
        read_chk(8'h10, "R1 reset mask", '0);
        read_chk(8'h28, "R1 reset tx threshold", DW'(1));
        read_chk(8'h2C, "R1 reset rx threshold", DW'(1));
        chk("R1 reset irq", DW'(irq), '0);
        @(negedge clk);
        rst = 1'b0;

        // TX below threshold sets bit 2, enable it (R5, R2, R11)
        idle(CW'(0), CW'(0));
        step(1'b1, 8'h08, 32'h04, CW'(0), CW'(0), 1'b0, 1'b0, 1'b0);
        // clear while condition holds: cleared, then back (R4, R10)
        step(1'b1, 8'h04, 32'h04, CW'(0), CW'(0), 1'b0, 1'b0, 1'b0);
        idle(CW'(0), CW'(0));
        // condition gone: clear stays (R10)
        step(1'b1, 8'h04, 32'h7F, CW'(1), CW'(0), 1'b0, 1'b0, 1'b0);
        idle(CW'(1), CW'(0));
        // mode fault and clear of it in the same cycle (R9)
        step(1'b1, 8'h04, 32'h02, CW'(1), CW'(0), 1'b0, 1'b0, 1'b1);
        step(1'b1, 8'h04, 32'h02, CW'(1), CW'(0), 1'b0, 1'b0, 1'b0);
        idle(CW'(1), CW'(0));
        // threshold clamps (R12)
        step(1'b1, 8'h2C, 32'd100, CW'(1), CW'(0), 1'b0, 1'b0, 1'b0);
        step(1'b1, 8'h2C, 32'h100, CW'(1), CW'(0), 1'b0, 1'b0, 1'b0);
        step(1'b1, 8'h28, 32'd64, CW'(1), CW'(0), 1'b0, 1'b0, 1'b0);
        // full RX with push, full TX, pop on empty TX (R7, R8, R9)
        step(1'b0, 8'h00, '0, CW'(DEPTH), CW'(DEPTH), 1'b1, 1'b0, 1'b0);
        step(1'b0, 8'h00, '0, CW'(0), CW'(63), 1'b0, 1'b1, 1'b0);
        // mask write to the readback offset is ignored; disable clears (R1, R3)
        step(1'b1, 8'h10, 32'h7F, CW'(0), CW'(0), 1'b0, 1'b0, 1'b0);
        step(1'b1, 8'h0C, 32'h04, CW'(0), CW'(0), 1'b0, 1'b0, 1'b0);
        // write-only and unmapped offsets read zero (R1)
        read_chk(8'h08, "R1 read of set offset", '0);
        read_chk(8'h0C, "R1 read of clear offset", '0);
        read_chk(8'h14, "R1 read of unmapped offset", '0);
        step(1'b1, 8'h28, 32'd1, CW'(0), CW'(0), 1'b0, 1'b0, 1'b0);
        step(1'b1, 8'h2C, 32'd32, CW'(0), CW'(0), 1'b0, 1'b0, 1'b0);

        // constrained random
        for (int n = 0; n < 3000; n++) begin
            logic [7:0]    wa;
            logic [DW-1:0] wd;
            logic          we;
            we = ($urandom_range(0, 2) == 0);
            case ($urandom_range(0, 7))
                0, 1: wa = 8'h04;
                2:    wa = 8'h08;
                3:    wa = 8'h0C;
                4:    wa = 8'h28;
                5:    wa = 8'h2C;
                6:    wa = 8'h10;
                default: wa = 8'h14;
            endcase
            if (wa == 8'h28 || wa == 8'h2C)
                wd = ($urandom_range(0, 7) == 0) ? DW'($urandom()) : DW'($urandom_range(0, 70));
            else
                wd = DW'($urandom());
            step(we, wa, wd, pick_level(e_txth), pick_level(e_rxth),
                 ($urandom_range(0, 3) == 0), ($urandom_range(0, 3) == 0),
                 ($urandom_range(0, 7) == 0));
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule